// File: doc/BRIEF.md
# Watchdog Timer with Two-Strobe Restart

This block supervises a running system. It counts the ticks of a selected timebase. If the program does not restart it before a programmable number of ticks has passed, the block raises a request. The timebase is either a slow, dedicated watchdog tick, given as a one-cycle enable on the system clock, or the system clock divided by four. The timeout is one base period multiplied by two raised to a 3-bit scale field. A scale of 7 therefore gives 128 base periods.

A restart needs two different clear strobes, `clr_a_i` and `clr_b_i`. Both must have been seen since the last restart, and their order does not matter. A program that is stuck in a loop issuing only one kind of clear therefore still times out. When the count expires, the block asserts a one-cycle reset request if the system is running, or a one-cycle wake-up request if it is powered down. With the divided system clock selected, power-down freezes the count, so no wake-up can come from it. With the dedicated tick selected, counting goes on in power-down. After an expiry the block starts a fresh timeout by itself.

All pins are plain control and status signals. No data flows through the block, so it has no valid/ready interface.

Top module: `wdog_dual_clear`

## Requirements
- R1: While `rst_n` is low both outputs are 0. After release with `enable_i`=1, `src_sel_i`=0 and `scale_i`=0, the reset request appears after exactly the 4th rising edge and not before.
- R2: With `src_sel_i`=0 (system clock divided by 4), the reset request is visible right after the rising edge 4·2^`scale_i` edges after the restart edge, and not earlier.
- R3: With `src_sel_i`=1, each clock cycle with `wdt_tick_i`=1 is one base period. The request is registered at the edge of the 2^`scale_i`-th tick after restart.
- R4: `scale_i`=7 gives a timeout of 128 base periods.
- R5: Repeated strobes of only one clear input, either `clr_a_i` alone or `clr_b_i` alone, never restart the count, and the timeout still occurs on schedule.
- R6: The count and the divide-by-4 phase both restart at the edge where the second of the two clear strobes is sampled. The order can be a then b, b then a, or both in one cycle. A restart in the same cycle as an expiry wins, and no request is issued.
- R7: An expiry while `pdown_i`=0 gives a `rst_req_o` pulse exactly one cycle wide, with `wake_o` kept at 0.
- R8: With `src_sel_i`=0 and `pdown_i`=1, the count and the prescaler hold their values and neither output is asserted. After power-down ends, counting resumes from the held value.
- R9: With `src_sel_i`=1, ticks are still counted while `pdown_i`=1. The expiry then gives a one-cycle `wake_o` pulse and no `rst_req_o`.
- R10: While `enable_i`=0, both outputs stay 0, clear strobes are ignored, and any clear already remembered is dropped. When `enable_i` rises, a full fresh timeout starts.
- R11: After an expiry the count starts again from zero, and the next request comes one full timeout later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Watchdog enable |
| src_sel_i | input | 1 | Timebase: 0 = system clock / 4, 1 = dedicated tick |
| wdt_tick_i | input | 1 | One-cycle enable from the low-speed watchdog clock |
| scale_i | input | 3 | Timeout exponent: timeout = 2^scale base periods |
| clr_a_i | input | 1 | First clear strobe |
| clr_b_i | input | 1 | Second clear strobe |
| pdown_i | input | 1 | System is powered down |
| rst_req_o | output | 1 | One-cycle reset request |
| wake_o | output | 1 | One-cycle wake-up request |

## Verification
The bench restarts the count in the middle of a prescaler phase. A design that failed to clear the divide-by-4 stage on restart would time out up to three cycles early. It places a two-strobe restart on the exact edge where the count would expire, which catches a design that lets the expiry win. It strobes one clear input repeatedly, and strobes a clear while the block is disabled, to catch a design that restarts on a single kind of clear or keeps clear memory across a disable. Power-down runs on both timebases expose a frozen count that wakes the system, a dedicated timebase that stalls, or a request sent to the wrong output.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic {
    SRC_SYSDIV    = 1'b0,
    SRC_DEDICATED = 1'b1
  } wdog_src_e;

endpackage

// File: rtl/wdog_tick_src.sv
module wdog_tick_src
  import wdog_pkg::*;
#(
  parameter int PRE_DIV = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enable,
  input  wdog_src_e src,
  input  logic      pdown,
  input  logic      ext_tick,
  input  logic      restart,
  output logic      tick
);

  // The divided system clock advances only while running and not powered down.
  logic adv_sys;
  logic sys_tick;

  assign adv_sys = enable && (src == SRC_SYSDIV) && !pdown;

  generate
    if (PRE_DIV > 1) begin : g_prescale
      localparam int PRE_W = $clog2(PRE_DIV);
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);

      logic [PRE_W-1:0] phase_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          phase_q <= '0;
        end else if (!enable || restart) begin
          phase_q <= '0;
        end else if (adv_sys) begin
          if (phase_q == PRE_LAST) phase_q <= '0;
          else                     phase_q <= phase_q + 1'b1;
        end
      end

      assign sys_tick = adv_sys && (phase_q == PRE_LAST);
    end else begin : g_direct
      assign sys_tick = adv_sys;
    end
  endgenerate

  always_comb begin
    unique case (src)
      SRC_SYSDIV:    tick = sys_tick;
      SRC_DEDICATED: tick = enable && ext_tick;
      default:       tick = 1'b0;
    endcase
  end

endmodule

// File: rtl/wdog_clear_pair.sv
module wdog_clear_pair (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic clr_a,
  input  logic clr_b,
  input  logic expire,
  output logic restart
);

  logic seen_a_q;
  logic seen_b_q;
  logic have_a;
  logic have_b;

  // A strobe counts in the cycle it arrives, so the order does not matter.
  assign have_a  = seen_a_q || clr_a;
  assign have_b  = seen_b_q || clr_b;
  assign restart = enable && have_a && have_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_a_q <= 1'b0;
      seen_b_q <= 1'b0;
    end else if (!enable || restart || expire) begin
      seen_a_q <= 1'b0;
      seen_b_q <= 1'b0;
    end else begin
      seen_a_q <= have_a;
      seen_b_q <= have_b;
    end
  end

endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             tick,
  input  logic             restart,
  input  logic [SEL_W-1:0] scale,
  output logic             expire
);

  localparam int CNT_W   = (1 << SEL_W) - 1;
  localparam int MAX_EXP = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_val;

  // Last count value before expiry: 2^scale - 1.
  always_comb begin
    last_val = '0;
    for (int k = 0; k <= MAX_EXP; k++) begin
      if (k < 32 && scale == SEL_W'(k)) last_val = CNT_W'((64'd1 << k) - 64'd1);
    end
  end

  // The compare uses >= so that a smaller scale written mid-run still ends the count.
  assign expire = enable && tick && !restart && (cnt_q >= last_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!enable || restart || expire) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/wdog_dual_clear.sv
module wdog_dual_clear
  import wdog_pkg::*;
#(
  parameter int SEL_W   = 3,
  parameter int PRE_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic             src_sel_i,
  input  logic             wdt_tick_i,
  input  logic [SEL_W-1:0] scale_i,
  input  logic             clr_a_i,
  input  logic             clr_b_i,
  input  logic             pdown_i,
  output logic             rst_req_o,
  output logic             wake_o
);

  wdog_src_e src;
  logic      tick;
  logic      restart;
  logic      expire;
  logic      rst_req_q;
  logic      wake_q;

  assign src = wdog_src_e'(src_sel_i);

  wdog_tick_src #(.PRE_DIV(PRE_DIV)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable_i),
    .src      (src),
    .pdown    (pdown_i),
    .ext_tick (wdt_tick_i),
    .restart  (restart),
    .tick     (tick)
  );

  wdog_clear_pair u_clear (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable_i),
    .clr_a   (clr_a_i),
    .clr_b   (clr_b_i),
    .expire  (expire),
    .restart (restart)
  );

  wdog_count #(.SEL_W(SEL_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable_i),
    .tick    (tick),
    .restart (restart),
    .scale   (scale_i),
    .expire  (expire)
  );

  // The request goes to reset while running and to wake-up while powered down.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req_q <= 1'b0;
      wake_q    <= 1'b0;
    end else begin
      rst_req_q <= expire && !pdown_i;
      wake_q    <= expire &&  pdown_i;
    end
  end

  assign rst_req_o = rst_req_q;
  assign wake_o    = wake_q;

endmodule

// File: rtl/wdog_dual_clear_chk.sv
module wdog_dual_clear_chk (
  input logic clk,
  input logic rst_n,
  input logic enable_i,
  input logic src_sel_i,
  input logic clr_a_i,
  input logic clr_b_i,
  input logic pdown_i,
  input logic rst_req_o,
  input logic wake_o
);

  // R7 / R9: one request kind at a time
  p_one_request_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req_o && wake_o));

  // R9: no reset request from an expiry in power-down
  p_no_rst_in_pdown_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> !$past(pdown_i));

  // R9: wake-up only follows a powered-down cycle
  p_wake_needs_pdown_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> $past(pdown_i));

  // R8: divided system clock cannot wake the system
  p_sysdiv_no_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pdown_i && !src_sel_i) |=> !wake_o);

  // R10: disabled block stays silent
  p_disabled_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> (!rst_req_o && !wake_o));

  // R6: a completed clear pair wins over a same-cycle expiry
  p_pair_beats_expiry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && clr_a_i && clr_b_i) |=> (!rst_req_o && !wake_o));

endmodule

bind wdog_dual_clear wdog_dual_clear_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable_i  (enable_i),
  .src_sel_i (src_sel_i),
  .clr_a_i   (clr_a_i),
  .clr_b_i   (clr_b_i),
  .pdown_i   (pdown_i),
  .rst_req_o (rst_req_o),
  .wake_o    (wake_o)
);

// File: tb/wdog_dual_clear_bench.sv
`timescale 1ns/100ps
module wdog_dual_clear_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable_i = 1'b1;
  logic       src_sel_i = 1'b0;
  logic       wdt_tick_i = 1'b0;
  logic [2:0] scale_i = 3'd0;
  logic       clr_a_i = 1'b0;
  logic       clr_b_i = 1'b0;
  logic       pdown_i = 1'b0;
  logic       rst_req_o;
  logic       wake_o;

  int total = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  wdog_dual_clear u_wdog_dual_clear (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable_i   (enable_i),
    .src_sel_i  (src_sel_i),
    .wdt_tick_i (wdt_tick_i),
    .scale_i    (scale_i),
    .clr_a_i    (clr_a_i),
    .clr_b_i    (clr_b_i),
    .pdown_i    (pdown_i),
    .rst_req_o  (rst_req_o),
    .wake_o     (wake_o)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic pair_restart();
    clr_a_i = 1'b1; clr_b_i = 1'b1;
    step();
    clr_a_i = 1'b0; clr_b_i = 1'b0;
  endtask

  // Pulse expected right after the n-th edge, for exactly one cycle.
  task automatic expect_timeout(int n, string tag);
    for (int i = 1; i <= n; i++) begin
      step();
      check({tag, " rst timing"}, rst_req_o, i == n);
    end
    check({tag, " no wake"}, wake_o, 1'b0);
    step();
    check({tag, " one-cycle"}, rst_req_o, 1'b0);
  endtask

  task automatic tick_once(output logic r, output logic w);
    wdt_tick_i = 1'b1;
    step();
    r = rst_req_o; w = wake_o;
    wdt_tick_i = 1'b0;
    step();
  endtask

  task automatic t_reset();
    for (int i = 0; i < 3; i++) begin
      step();
      check("R1 rst during reset", rst_req_o, 1'b0);
      check("R1 wake during reset", wake_o, 1'b0);
    end
    rst_n = 1'b1;
    expect_timeout(4, "R1 first timeout");
  endtask

  task automatic t_sys_timeout();
    src_sel_i = 1'b0;
    scale_i = 3'd2;
    pair_restart();
    expect_timeout(16, "R2 R7 scale2");
    scale_i = 3'd3;
    pair_restart();
    expect_timeout(32, "R2 R7 scale3");
  endtask

  task automatic t_dedicated();
    logic r, w;
    src_sel_i = 1'b1;
    scale_i = 3'd7;
    pair_restart();
    for (int round = 0; round < 2; round++) begin
      for (int i = 1; i <= 128; i++) begin
        tick_once(r, w);
        check(round == 0 ? "R3 R4 tick timeout" : "R11 repeat timeout", r, i == 128);
        check("R3 no wake", w, 1'b0);
      end
      check("R7 pulse ended", rst_req_o, 1'b0);
    end
  endtask

  task automatic t_single_clear();
    src_sel_i = 1'b0;
    scale_i = 3'd2;
    pair_restart();
    for (int i = 1; i <= 16; i++) begin
      clr_a_i = (i % 3 == 1);
      step();
      check("R5 only clr_a", rst_req_o, i == 16);
    end
    clr_a_i = 1'b0;
    for (int i = 1; i <= 16; i++) begin
      clr_b_i = (i % 3 == 1);
      step();
      check("R5 R11 only clr_b", rst_req_o, i == 16);
    end
    clr_b_i = 1'b0;
  endtask

  task automatic t_clear_order();
    src_sel_i = 1'b0;
    scale_i = 3'd2;
    pair_restart();
    for (int i = 1; i <= 10; i++) step();
    clr_b_i = 1'b1; step(); clr_b_i = 1'b0;
    step(); step();
    clr_a_i = 1'b1; step(); clr_a_i = 1'b0;
    check("R6 b-then-a no early pulse", rst_req_o, 1'b0);
    expect_timeout(16, "R6 b-then-a restart");
    pair_restart();
    for (int i = 1; i <= 15; i++) step();
    clr_a_i = 1'b1; clr_b_i = 1'b1;
    step();
    clr_a_i = 1'b0; clr_b_i = 1'b0;
    check("R6 restart beats expiry", rst_req_o, 1'b0);
    expect_timeout(16, "R6 after priority restart");
  endtask

  task automatic t_pdown_sys();
    src_sel_i = 1'b0;
    scale_i = 3'd2;
    pair_restart();
    for (int i = 1; i <= 8; i++) step();
    pdown_i = 1'b1;
    for (int i = 1; i <= 40; i++) begin
      step();
      check("R8 frozen no wake", wake_o, 1'b0);
      check("R8 frozen no rst", rst_req_o, 1'b0);
    end
    pdown_i = 1'b0;
    expect_timeout(8, "R8 resume");
  endtask

  task automatic t_pdown_ded();
    logic r, w;
    src_sel_i = 1'b1;
    scale_i = 3'd1;
    pair_restart();
    pdown_i = 1'b1;
    tick_once(r, w);
    check("R9 first tick no wake", w, 1'b0);
    tick_once(r, w);
    check("R9 wake on expiry", w, 1'b1);
    check("R9 no rst in pdown", r, 1'b0);
    check("R9 wake one-cycle", wake_o, 1'b0);
    pdown_i = 1'b0;
  endtask

  task automatic t_disable();
    src_sel_i = 1'b0;
    scale_i = 3'd2;
    pair_restart();
    clr_a_i = 1'b1; step(); clr_a_i = 1'b0;
    step();
    enable_i = 1'b0;
    for (int i = 1; i <= 5; i++) begin
      clr_b_i = (i == 3);
      step();
      check("R10 disabled quiet", rst_req_o | wake_o, 1'b0);
    end
    clr_b_i = 1'b0;
    enable_i = 1'b1;
    for (int i = 1; i <= 16; i++) begin
      clr_b_i = (i == 10);
      step();
      check("R10 fresh start, memory dropped", rst_req_o, i == 16);
    end
    clr_b_i = 1'b0;
  endtask

  initial begin
    #1;
    t_reset();
    t_sys_timeout();
    t_dedicated();
    t_single_clear();
    t_clear_order();
    t_pdown_sys();
    t_pdown_ded();
    t_disable();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    total++;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule